// File: doc/BRIEF.md
# Multiport Register File from Replicated Two-Port Memories

This block is a 32-entry, 32-bit register file with two write ports and five read ports. Four read ports serve a pair of instructions issued together and the fifth serves a debug viewer. No memory in the block has more than one read port and one write port, and no clock faster than the pipeline clock is used.

Every write port has its own row of memories. That row holds one copy of the storage for each read port, and all copies in the row take the same write, so they always agree. A live-value table, one small entry per register, remembers which write port last wrote that register. Each read port reads its own copy in every row at once, and the table entry for its address picks the row that holds the newest value. Memory reads are registered. The table lookup is registered too, so the row choice lines up with the data. A write therefore reaches the read data outputs two cycles after it is presented, and the pipeline around the file must bypass across that window.

Top module: `mprf_top`

## Requirements
- R1: While reset is asserted, and in the cycle after any reset edge, every read data output is zero.
- R2: A value written through either write port to register k (k from 1 to 31) is returned by any read port that presents address k in a later cycle, as long as no newer write to k has taken place.
- R3: The five read ports work on their own: in one cycle each may present a different address, and each returns the value held at its own address.
- R4: Read data is registered. An address presented in cycle c is answered in cycle c+1 with the contents as they stood before any write presented in cycle c. A write presented in cycle c is first seen in read data in cycle c+2.
- R5: When both write ports are enabled with the same address in one cycle, the value on write port 1 is the one kept. The live-value entry for that register then holds index 1.
- R6: Address 0 always reads as zero, whatever has been written to it.
- R7: The live-value entry of a register holds the index of the write port that wrote it last. A later write from port 0 replaces an earlier one from port 1, and the other way round.
- R8: A write port whose enable is low changes no register, whatever its address and data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 2 | Write enable, one bit per write port |
| wr_addr | input | 2x5 | Write address per write port |
| wr_data | input | 2x32 | Write data per write port |
| rd_addr | input | 5x5 | Read address per read port |
| rd_data | output | 5x32 | Read data per read port, valid one cycle after the address |

## Verification
The hardest cases come from timing between the ports: a read and a write to the same register in the same cycle, and both write ports hitting one register together. Only these cases show whether the table and the memory rows stay in step. The stimulus reaches them with directed cycles: it writes a register and reads it on the same edge, then on the next edge. It drives both write ports to one address with different data. It alternates the writing port for one register across consecutive cycles. A long random phase then draws all addresses from the 32 registers, so that collisions and same-cycle read/write overlaps happen often. Every read port is compared against the reference model on every clock.

// File: rtl/mprf_pkg.sv
package mprf_pkg;

  localparam int unsigned RF_ENTRIES = 32;
  localparam int unsigned RF_BITS    = 32;
  localparam int unsigned RF_WPORTS  = 2;
  localparam int unsigned RF_RPORTS  = 5;

  // Width of an index able to name n items (at least one bit)
  function automatic int unsigned rf_idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rf_ram_1r1w.sv
module rf_ram_1r1w #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Write side: no reset on the storage array
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read; returns contents from before a same-edge write
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/rf_lvt.sv
module rf_lvt #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NWR   = 2,
  parameter int unsigned NRD   = 5,
  parameter int unsigned AW    = 5,
  parameter int unsigned SW    = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NWR-1:0]              wr_en,
  input  logic [NWR-1:0][AW-1:0]      wr_addr,
  input  logic [NRD-1:0][AW-1:0]      rd_addr,
  output logic [NRD-1:0][SW-1:0]      rd_sel,
  output logic [NRD-1:0]              rd_zero,
  output logic [DEPTH-1:0][SW-1:0]    owner_q
);

  // Ascending port order: a higher port overrides a lower one on collision
  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
    end else begin
      for (int w = 0; w < int'(NWR); w++) begin
        if (wr_en[w]) owner_q[wr_addr[w]] <= SW'(w);
      end
    end
  end

  // Lookup delayed one cycle to align with the registered memory read
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel  <= '0;
      rd_zero <= '1;
    end else begin
      for (int p = 0; p < int'(NRD); p++) begin
        rd_sel[p]  <= owner_q[rd_addr[p]];
        rd_zero[p] <= (rd_addr[p] == '0);
      end
    end
  end

endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int unsigned NWR   = 2,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SW    = 1
) (
  input  logic [NWR-1:0][WIDTH-1:0] row_data,
  input  logic [SW-1:0]             sel,
  input  logic                      force_zero,
  output logic [WIDTH-1:0]          dout
);

  always_comb begin
    dout = '0;
    for (int w = 0; w < int'(NWR); w++) begin
      if (sel == SW'(w)) dout = row_data[w];
    end
    if (force_zero) dout = '0;
  end

endmodule

// File: rtl/mprf_top.sv
module mprf_top
  import mprf_pkg::*;
#(
  parameter int unsigned NREG = RF_ENTRIES,
  parameter int unsigned W    = RF_BITS,
  parameter int unsigned NWR  = RF_WPORTS,
  parameter int unsigned NRD  = RF_RPORTS,
  localparam int unsigned AW  = rf_idx_bits(NREG),
  localparam int unsigned SW  = rf_idx_bits(NWR)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWR-1:0]          wr_en,
  input  logic [NWR-1:0][AW-1:0]  wr_addr,
  input  logic [NWR-1:0][W-1:0]   wr_data,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][W-1:0]   rd_data
);

  // Named internal wires, also observed by the bound checker
  logic [NWR-1:0][NRD-1:0][W-1:0] bank_rdata;
  logic [NRD-1:0][NWR-1:0][W-1:0] col_data;
  logic [NREG-1:0][SW-1:0]        lvt_table;
  logic [NRD-1:0][SW-1:0]         rd_sel;
  logic [NRD-1:0]                 rd_zero;

  // Grid of memories: row = write port, column = read port
  for (genvar w = 0; w < NWR; w++) begin : g_row
    for (genvar p = 0; p < NRD; p++) begin : g_col
      rf_ram_1r1w #(
        .DEPTH (NREG),
        .WIDTH (W),
        .AW    (AW)
      ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en[w]),
        .waddr (wr_addr[w]),
        .wdata (wr_data[w]),
        .raddr (rd_addr[p]),
        .rdata (bank_rdata[w][p])
      );
      assign col_data[p][w] = bank_rdata[w][p];
    end
  end

  rf_lvt #(
    .DEPTH (NREG),
    .NWR   (NWR),
    .NRD   (NRD),
    .AW    (AW),
    .SW    (SW)
  ) u_lvt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rd_sel  (rd_sel),
    .rd_zero (rd_zero),
    .owner_q (lvt_table)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_read_mux #(
      .NWR   (NWR),
      .WIDTH (W),
      .SW    (SW)
    ) u_mux (
      .row_data   (col_data[p]),
      .sel        (rd_sel[p]),
      .force_zero (rd_zero[p]),
      .dout       (rd_data[p])
    );
  end

endmodule

// File: rtl/mprf_checker.sv
module mprf_checker #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  parameter int unsigned NWR  = 2,
  parameter int unsigned NRD  = 5,
  parameter int unsigned AW   = 5,
  parameter int unsigned SW   = 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NWR-1:0]               wr_en,
  input logic [NWR-1:0][AW-1:0]       wr_addr,
  input logic [NRD-1:0][AW-1:0]       rd_addr,
  input logic [NRD-1:0][W-1:0]        rd_data,
  input logic [NREG-1:0][SW-1:0]      lvt_table,
  input logic [NWR-1:0][NRD-1:0][W-1:0] bank_rdata
);

  // A port is beaten when some higher port writes the same address
  logic [NWR-1:0] beaten;
  always_comb begin
    beaten = '0;
    for (int w = 0; w < int'(NWR); w++) begin
      for (int h = w + 1; h < int'(NWR); h++) begin
        if (wr_en[h] && wr_addr[h] == wr_addr[w]) beaten[w] = 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_p
    // R6: address zero answers zero
    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_addr[p] == '0) |=> (rd_data[p] == '0));

    // R3: all copies in a row agree when read at the same address
    for (genvar w = 0; w < NWR; w++) begin : g_w
      if (p > 0) begin : g_cmp
        assert_row_copies_R3: assert property (@(posedge clk) disable iff (rst)
          (rd_addr[p] == rd_addr[0]) |=> (bank_rdata[w][p] == bank_rdata[w][0]));
      end
    end
  end

  for (genvar w = 0; w < NWR; w++) begin : g_own
    // R7: an unbeaten write leaves its port index in the table
    assert_owner_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en[w] && !beaten[w]) |=> (lvt_table[$past(wr_addr[w])] == SW'(w)));
  end

  // R5: same-address collision is owned by the highest port
  assert_collision_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en[0] && wr_en[NWR-1] && wr_addr[0] == wr_addr[NWR-1])
    |=> (lvt_table[$past(wr_addr[NWR-1])] == SW'(NWR-1)));

endmodule

bind mprf_top mprf_checker #(
  .NREG (NREG),
  .W    (W),
  .NWR  (NWR),
  .NRD  (NRD),
  .AW   (AW),
  .SW   (SW)
) u_mprf_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .lvt_table  (lvt_table),
  .bank_rdata (bank_rdata)
);

// File: tb/mprf_top_bench.sv
module mprf_top_bench;

  localparam int NREG = 32;
  localparam int W    = 32;
  localparam int NWR  = 2;
  localparam int NRD  = 5;
  localparam int AW   = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst;
  logic [NWR-1:0]         wr_en;
  logic [NWR-1:0][AW-1:0] wr_addr;
  logic [NWR-1:0][W-1:0]  wr_data;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][W-1:0]  rd_data;

  mprf_top u_mprf_top (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model: plain arrays, no structure of the design
  logic [W-1:0] model [NREG];
  bit           known [NREG];
  logic [W-1:0] exp_q [NRD];
  bit           exp_ok[NRD];
  string        exp_tag = "R1";
  string        cur_tag = "R1";

  task automatic check(input bit ok, input string tag, input int port,
                       input logic [W-1:0] got, input logic [W-1:0] want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s port %0d got=%h expected=%h", tag, port, got, want);
    end
  endtask

  // Model step at each edge: answer with pre-write contents, then apply
  // writes in ascending port order so the higher port keeps a collision.
  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NRD; p++) begin
        exp_q[p]  = '0;
        exp_ok[p] = 1'b1;
      end
      exp_tag = "R1";
    end else begin
      for (int p = 0; p < NRD; p++) begin
        if (rd_addr[p] == '0) begin
          exp_q[p]  = '0;
          exp_ok[p] = 1'b1;
        end else begin
          exp_q[p]  = model[rd_addr[p]];
          exp_ok[p] = known[rd_addr[p]];
        end
      end
      exp_tag = cur_tag;
      for (int w = 0; w < NWR; w++) begin
        if (wr_en[w]) begin
          model[wr_addr[w]] = wr_data[w];
          known[wr_addr[w]] = 1'b1;
        end
      end
    end
  end

  // Compare every port on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int p = 0; p < NRD; p++) begin
        if (exp_ok[p])
          check(rd_data[p] === exp_q[p], exp_tag, p, rd_data[p], exp_q[p]);
      end
    end
  end

  task automatic drive(input logic [NWR-1:0] we,
                       input int a0, input logic [W-1:0] d0,
                       input int a1, input logic [W-1:0] d1,
                       input int r0, input int r1, input int r2,
                       input int r3, input int r4, input string tag);
    @(negedge clk);
    wr_en      = we;
    wr_addr[0] = AW'(a0);
    wr_data[0] = d0;
    wr_addr[1] = AW'(a1);
    wr_data[1] = d1;
    rd_addr[0] = AW'(r0);
    rd_addr[1] = AW'(r1);
    rd_addr[2] = AW'(r2);
    rd_addr[3] = AW'(r3);
    rd_addr[4] = AW'(r4);
    cur_tag    = tag;
  endtask

  task automatic idle_read(input int a, input string tag);
    drive(2'b00, 0, '0, 0, '0, a, a, a, a, a, tag);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      model[i] = '0;
      known[i] = 1'b0;
    end
    rst     = 1'b1;
    wr_en   = '0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    repeat (3) @(posedge clk);
    // R1: outputs are zero under reset
    @(negedge clk);
    for (int p = 0; p < NRD; p++)
      check(rd_data[p] == '0, "R1 reset", p, rd_data[p], '0);
    rst = 1'b0;

    // R2: fill every register, alternating the writing port
    for (int k = 1; k < NREG; k += 2) begin
      drive(2'b11, k, 32'h1000_0000 + k, (k + 1) % NREG, 32'h2000_0000 + k,
            0, 0, 0, 0, 0, "R2 fill");
    end
    for (int k = 1; k < NREG; k++) idle_read(k, "R2 readback");

    // R4: write r5 and read it the same cycle (old), then next (still old
    // at output of that cycle), then after (new)
    drive(2'b01, 5, 32'hA5A5_0005, 0, '0, 5, 5, 5, 5, 5, "R4 same cycle");
    idle_read(5, "R4 next cycle");
    idle_read(5, "R4 visible");

    // R5: collision on r7, port 1 must win
    drive(2'b11, 7, 32'h0000_0A00, 7, 32'h0000_0B01, 0, 0, 0, 0, 0, "R5 collide");
    idle_read(7, "R5 winner");
    idle_read(7, "R5 winner");

    // R7: alternate owner of r9 across consecutive cycles
    drive(2'b10, 0, '0, 9, 32'h9999_0001, 0, 0, 0, 0, 0, "R7 port1 first");
    drive(2'b01, 9, 32'h9999_0000, 0, '0, 9, 9, 9, 9, 9, "R7 port0 later");
    idle_read(9, "R7 latest");
    idle_read(9, "R7 latest");
    drive(2'b10, 0, '0, 9, 32'h9999_0002, 0, 0, 0, 0, 0, "R7 port1 again");
    idle_read(9, "R7 latest");
    idle_read(9, "R7 latest");

    // R6: writes to r0 are never seen
    drive(2'b11, 0, 32'hFFFF_FFFF, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, "R6 write r0");
    idle_read(0, "R6 read r0");
    idle_read(0, "R6 read r0");

    // R8: disabled ports with live address and data change nothing
    drive(2'b00, 3, 32'hBAD0_0003, 3, 32'hBAD1_0003, 3, 3, 3, 3, 3, "R8 disabled");
    idle_read(3, "R8 unchanged");
    idle_read(3, "R8 unchanged");

    // R3: five different addresses in one cycle
    drive(2'b00, 0, '0, 0, '0, 1, 8, 15, 22, 31, "R3 spread");
    drive(2'b00, 0, '0, 0, '0, 31, 22, 15, 8, 1, "R3 spread");

    // Random phase: collisions and same-cycle overlaps are frequent
    for (int n = 0; n < 4000; n++) begin
      drive(NWR'($urandom), int'($urandom % NREG), W'($urandom),
            int'($urandom % NREG), W'($urandom),
            int'($urandom % NREG), int'($urandom % NREG), int'($urandom % NREG),
            int'($urandom % NREG), int'($urandom % NREG), "R3 R5 R7 random");
    end
    idle_read(1, "R2 tail");
    idle_read(1, "R2 tail");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule